// File: doc/BRIEF.md
# Ethernet PHY Basic Control Register

This block holds the sixteen-bit basic mode register of an Ethernet physical-layer device. A management agent reaches it through a plain port made up of a select line, a write strobe, write data and combinational read data. The block drives each mode bit out as a separate control line toward the parts of the PHY that are not in this block: speed, auto-negotiation, power-down, isolation and duplex.

A write with the top bit set starts a soft reset. The control bits return to their defaults at once. The top bit then reads as 1 for a fixed, parameterised number of cycles. That number stands in for the 500 ms limit and is kept short in simulation. The bit then clears by itself, and a one-cycle done pulse is raised. Writes that arrive while the reset is pending are dropped. The isolate default depends on the strapped PHY address.

The block also owns the small path toward the MAC. In loopback it returns the transmit nibble and its enable to the receive side in the same cycle and silences the line. Collision reporting follows the collision-test bit in loopback. Isolation forces the MAC-facing receive signals to zero.

Top module: `phy_ctrl_reg`

## Requirements
- R1: Writing with bit 15 = 1 (while no soft reset is pending) sets the pending state from the next cycle. Bit 15 of the read data is 1 for exactly RESET_CYCLES cycles and then returns to 0. `resetDone` is high for the single cycle after it clears.
- R2: Any write arriving while a soft reset is pending is discarded. This applies to every bit, including bit 15.
- R3: Defaults are bit 13 speed = 1 (100 Mb/s) and bit 12 auto-negotiation enable = 1. Bit 14 loopback, bit 11 power-down, bit 9 restart auto-negotiation, bit 8 duplex (1 = full) and bit 7 collision test are all 0. Bit 10 isolate is 1 when `phyAddr` is 0 and 0 otherwise. The soft reset loads these defaults in the cycle after its start write.
- R4: A write with bit 15 = 0 and no reset pending loads bits 14:7 from the write data. From the next cycle they appear on the read data and on the matching control outputs.
- R5: When `mgmtSel` is high, `mgmtRdata` shows the register in the same cycle. When it is low, `mgmtRdata` is 0. Bits 6:0 always read 0, whatever was written to them.
- R6: With loopback set and isolate clear, `macRxData`/`macRxDv` equal `macTxData`/`macTxEn` in the same cycle. With loopback set, `lineTxData` and `lineTxEn` are 0.
- R7: With loopback set and isolate clear, `macCol` is 0 when collision test is clear and equals `macTxEn` when collision test is set.
- R8: With loopback and isolate clear, `macRxData`, `macRxDv` and `macCol` follow the line inputs, and the line transmit outputs follow the MAC transmit inputs.
- R9: With isolate set, `macRxData`, `macRxDv` and `macCol` are 0 regardless of loopback.
- R10: The active-low hardware reset loads the R3 defaults and aborts a pending soft reset without a `resetDone` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| phyAddr | input | 5 | Strapped PHY address |
| mgmtSel | input | 1 | Management address match for this register |
| mgmtWe | input | 1 | Management write strobe |
| mgmtWdata | input | 16 | Management write data |
| mgmtRdata | output | 16 | Management read data |
| macTxData | input | 4 | Transmit nibble from the MAC |
| macTxEn | input | 1 | Transmit enable from the MAC |
| macRxData | output | 4 | Receive nibble to the MAC |
| macRxDv | output | 1 | Receive data valid to the MAC |
| macCol | output | 1 | Collision indication to the MAC |
| lineTxData | output | 4 | Transmit nibble to the line side |
| lineTxEn | output | 1 | Transmit enable to the line side |
| lineRxData | input | 4 | Receive nibble from the line side |
| lineRxDv | input | 1 | Receive valid from the line side |
| lineCol | input | 1 | Collision from the line side |
| loopback | output | 1 | Loopback mode active |
| speed100 | output | 1 | 100 Mb/s selected |
| anEnable | output | 1 | Auto-negotiation enabled |
| powerDown | output | 1 | Reduced-power mode requested |
| isolate | output | 1 | PHY isolated from the MAC |
| anRestart | output | 1 | Auto-negotiation restart requested |
| fullDuplex | output | 1 | Full duplex selected |
| colTest | output | 1 | Collision test enabled |
| resetDone | output | 1 | One-cycle pulse when a soft reset completes |

## Verification
The assertions assume that `phyAddr` is a static strap that stays constant while `rstN` is high. The stimulus changes it only while the hardware reset is asserted. They also assume that write strobes count only when `mgmtSel` is high. The bench keeps `mgmtWe` low whenever it drops the select. All inputs change on the falling edge, so the loopback and isolate paths, which have no register, are checked in the same cycle their inputs settle. The hardware reset is pulsed in the middle of a soft reset to cover the abort path.

// File: rtl/phy_ctrl_pkg.sv
package phy_ctrl_pkg;
  localparam int REG_W = 16;
  localparam int BIT_RESET = 15;
  localparam int MODE_HI = 14;
  localparam int MODE_LO = 7;
  localparam int MODE_W = MODE_HI - MODE_LO + 1;

  // offsets of each mode bit inside the stored slice (register bit minus MODE_LO)
  localparam int M_LOOP  = 7;
  localparam int M_SPEED = 6;
  localparam int M_AN    = 5;
  localparam int M_PDOWN = 4;
  localparam int M_ISO   = 3;
  localparam int M_ANRST = 2;
  localparam int M_DUPLX = 1;
  localparam int M_COLT  = 0;

  typedef struct packed {
    logic loadDefaults;
    logic loadWrite;
  } ctrlStrobe_t;
endpackage

// File: rtl/phy_ctrl_seq.sv
module phy_ctrl_seq
  import phy_ctrl_pkg::*;
#(
  parameter int RESET_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrReq,
  input  logic        wrResetBit,
  output ctrlStrobe_t strobe,
  output logic        resetPending,
  output logic        resetDone
);
  localparam int CNT_W = (RESET_CYCLES > 2) ? $clog2(RESET_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RESET_CYCLES - 1);

  logic [CNT_W-1:0] holdCnt;
  logic acceptWrite;

  assign acceptWrite = wrReq && !resetPending;
  assign strobe.loadDefaults = acceptWrite && wrResetBit;
  assign strobe.loadWrite    = acceptWrite && !wrResetBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resetPending <= 1'b0;
      resetDone    <= 1'b0;
      holdCnt      <= '0;
    end else begin
      resetDone <= 1'b0;
      if (resetPending) begin
        if (holdCnt == '0) begin
          resetPending <= 1'b0;
          resetDone    <= 1'b1;
        end else begin
          holdCnt <= holdCnt - 1'b1;
        end
      end else if (strobe.loadDefaults) begin
        resetPending <= 1'b1;
        holdCnt      <= CNT_LOAD;
      end
    end
  end

  // R1: completion is always announced by the done pulse
  p_done_on_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resetPending) |-> resetDone);
  // R1: done never appears while a reset is still pending
  p_done_exclusive_r1: assert property (@(posedge clk) disable iff (!rstN)
    resetDone |-> !resetPending);
  // R2: a pending reset lets no write strobe through
  p_block_writes_r2: assert property (@(posedge clk) disable iff (!rstN)
    resetPending |-> !(strobe.loadWrite || strobe.loadDefaults));
endmodule

// File: rtl/phy_ctrl_data.sv
module phy_ctrl_data
  import phy_ctrl_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] phyAddr,
  input  ctrlStrobe_t       strobe,
  input  logic [MODE_W-1:0] wrMode,
  input  logic              resetPending,
  input  logic              rdSel,
  output logic [REG_W-1:0]  rdData,
  output logic [MODE_W-1:0] modeBits,
  input  logic [NIB_W-1:0]  macTxData,
  input  logic              macTxEn,
  output logic [NIB_W-1:0]  macRxData,
  output logic              macRxDv,
  output logic              macCol,
  output logic [NIB_W-1:0]  lineTxData,
  output logic              lineTxEn,
  input  logic [NIB_W-1:0]  lineRxData,
  input  logic              lineRxDv,
  input  logic              lineCol
);
  logic [MODE_W-1:0] defaultMode;
  logic loopOn, isoOn, colTestOn;

  always_comb begin
    defaultMode = '0;
    defaultMode[M_SPEED] = 1'b1;
    defaultMode[M_AN]    = 1'b1;
    defaultMode[M_ISO]   = (phyAddr == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    modeBits <= defaultMode;
    else if (strobe.loadDefaults) modeBits <= defaultMode;
    else if (strobe.loadWrite)    modeBits <= wrMode;
  end

  assign loopOn    = modeBits[M_LOOP];
  assign isoOn     = modeBits[M_ISO];
  assign colTestOn = modeBits[M_COLT];

  always_comb begin
    rdData = '0;
    if (rdSel) begin
      rdData[BIT_RESET] = resetPending;
      rdData[MODE_HI:MODE_LO] = modeBits;
    end
  end

  always_comb begin
    lineTxData = loopOn ? '0 : macTxData;
    lineTxEn   = loopOn ? 1'b0 : macTxEn;
    if (isoOn) begin
      macRxData = '0;
      macRxDv   = 1'b0;
      macCol    = 1'b0;
    end else if (loopOn) begin
      macRxData = macTxData;
      macRxDv   = macTxEn;
      macCol    = colTestOn && macTxEn;
    end else begin
      macRxData = lineRxData;
      macRxDv   = lineRxDv;
      macCol    = lineCol;
    end
  end

  // R2: mode bits cannot move during a pending reset
  p_frozen_r2: assert property (@(posedge clk) disable iff (!rstN)
    (resetPending && $past(resetPending)) |-> $stable(modeBits));
  // R7: loopback without collision test keeps collision quiet
  p_loop_col_r7: assert property (@(posedge clk) disable iff (!rstN)
    (loopOn && !colTestOn) |-> !macCol);
  // R9: isolation silences the MAC receive side
  p_isolate_r9: assert property (@(posedge clk) disable iff (!rstN)
    isoOn |-> (!macRxDv && !macCol && macRxData == '0));
  // R6: the line transmitter is quiet in loopback
  p_loop_line_r6: assert property (@(posedge clk) disable iff (!rstN)
    loopOn |-> (!lineTxEn && lineTxData == '0));
  // R5: reserved bits never read back as 1
  p_reserved_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdData[MODE_LO-1:0] == '0);
endmodule

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
  import phy_ctrl_pkg::*;
#(
  parameter int RESET_CYCLES = 16,
  parameter int ADDR_W = 5,
  parameter int NIB_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] phyAddr,
  input  logic              mgmtSel,
  input  logic              mgmtWe,
  input  logic [REG_W-1:0]  mgmtWdata,
  output logic [REG_W-1:0]  mgmtRdata,
  input  logic [NIB_W-1:0]  macTxData,
  input  logic              macTxEn,
  output logic [NIB_W-1:0]  macRxData,
  output logic              macRxDv,
  output logic              macCol,
  output logic [NIB_W-1:0]  lineTxData,
  output logic              lineTxEn,
  input  logic [NIB_W-1:0]  lineRxData,
  input  logic              lineRxDv,
  input  logic              lineCol,
  output logic              loopback,
  output logic              speed100,
  output logic              anEnable,
  output logic              powerDown,
  output logic              isolate,
  output logic              anRestart,
  output logic              fullDuplex,
  output logic              colTest,
  output logic              resetDone
);
  ctrlStrobe_t strobe;
  logic resetPending;
  logic [MODE_W-1:0] modeBits;
  logic [MODE_LO-1:0] unusedWdata;

  assign unusedWdata = mgmtWdata[MODE_LO-1:0];

  phy_ctrl_seq #(.RESET_CYCLES(RESET_CYCLES)) u_seq (
    .clk(clk), .rstN(rstN),
    .wrReq(mgmtSel && mgmtWe),
    .wrResetBit(mgmtWdata[BIT_RESET]),
    .strobe(strobe),
    .resetPending(resetPending),
    .resetDone(resetDone)
  );

  phy_ctrl_data #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_data (
    .clk(clk), .rstN(rstN), .phyAddr(phyAddr),
    .strobe(strobe),
    .wrMode(mgmtWdata[MODE_HI:MODE_LO]),
    .resetPending(resetPending),
    .rdSel(mgmtSel), .rdData(mgmtRdata),
    .modeBits(modeBits),
    .macTxData(macTxData), .macTxEn(macTxEn),
    .macRxData(macRxData), .macRxDv(macRxDv), .macCol(macCol),
    .lineTxData(lineTxData), .lineTxEn(lineTxEn),
    .lineRxData(lineRxData), .lineRxDv(lineRxDv), .lineCol(lineCol)
  );

  assign loopback   = modeBits[M_LOOP];
  assign speed100   = modeBits[M_SPEED];
  assign anEnable   = modeBits[M_AN];
  assign powerDown  = modeBits[M_PDOWN];
  assign isolate    = modeBits[M_ISO];
  assign anRestart  = modeBits[M_ANRST];
  assign fullDuplex = modeBits[M_DUPLX];
  assign colTest    = modeBits[M_COLT];
endmodule

// File: tb/phy_ctrl_reg_test.sv
module phy_ctrl_reg_test;
  localparam int RC = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] phyAddr = 5'd0;
  logic mgmtSel = 1'b0, mgmtWe = 1'b0;
  logic [15:0] mgmtWdata = '0;
  logic [15:0] mgmtRdata;
  logic [3:0] macTxData = '0, macRxData, lineTxData, lineRxData = '0;
  logic macTxEn = 1'b0, macRxDv, macCol, lineTxEn, lineRxDv = 1'b0, lineCol = 1'b0;
  logic loopback, speed100, anEnable, powerDown, isolate, anRestart, fullDuplex, colTest, resetDone;

  int checks = 0;
  int errors = 0;

  phy_ctrl_reg #(.RESET_CYCLES(RC)) uut (.*);

  always #10 clk = ~clk;

  // reference model: register bits 14:7 held as a 16-bit word, pending as bit 15
  logic [15:0] mReg;
  int mCnt;
  logic mDone;

  function automatic logic [15:0] defWord(input logic [4:0] a);
    logic [15:0] w;
    w = 16'h3000;
    if (a == 5'd0) w[10] = 1'b1;
    return w;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mReg <= defWord(phyAddr);
      mCnt <= 0;
      mDone <= 1'b0;
    end else begin
      mDone <= 1'b0;
      if (mReg[15]) begin
        if (mCnt == 1) begin
          mReg[15] <= 1'b0;
          mDone <= 1'b1;
        end
        mCnt <= mCnt - 1;
      end else if (mgmtSel && mgmtWe) begin
        if (mgmtWdata[15]) begin
          mReg <= defWord(phyAddr) | 16'h8000;
          mCnt <= RC;
        end else begin
          mReg <= {1'b0, mgmtWdata[14:7], 7'b0};
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    logic [3:0] eRx; logic eDv, eCol;
    chk("R5 read data", mgmtRdata, mgmtSel ? mReg : 16'h0);
    chk("R3/R4 mode outputs",
        {8'h0, loopback, speed100, anEnable, powerDown, isolate, anRestart, fullDuplex, colTest},
        {8'h0, mReg[14:7]});
    chk("R1 done pulse", {15'h0, resetDone}, {15'h0, mDone});
    if (mReg[10]) begin
      eRx = 0; eDv = 0; eCol = 0;
    end else if (mReg[14]) begin
      eRx = macTxData; eDv = macTxEn; eCol = mReg[7] & macTxEn;
    end else begin
      eRx = lineRxData; eDv = lineRxDv; eCol = lineCol;
    end
    chk("R6/R8/R9 receive path", {10'h0, macRxData, macRxDv, macCol}, {10'h0, eRx, eDv, eCol});
    chk("R7 collision", {15'h0, macCol}, {15'h0, eCol});
    chk("R6 line transmit", {11'h0, lineTxData, lineTxEn},
        mReg[14] ? 16'h0 : {11'h0, macTxData, macTxEn});
  endtask

  always @(negedge clk) if (rstN) compareAll();

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] d);
    mgmtSel = 1'b1; mgmtWe = 1'b1; mgmtWdata = d;
    @(negedge clk);
    mgmtWe = 1'b0;
  endtask

  task automatic traffic(input int n);
    for (int i = 0; i < n; i++) begin
      macTxData = 4'(i * 3 + 1); macTxEn = i[0] | i[1];
      lineRxData = 4'(i * 5 + 2); lineRxDv = i[1]; lineCol = i[2];
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    cyc(20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R3 defaults with address 0: isolate set
    phyAddr = 5'd0;
    cyc(2); rstN = 1'b1;
    mgmtSel = 1'b1; cyc(1);
    chk("R3 default addr0", mgmtRdata, 16'h3400);
    traffic(6);                                 // R9 isolated
    // R3 defaults with non-zero address
    rstN = 1'b0; phyAddr = 5'd3; cyc(2); rstN = 1'b1; cyc(1);
    chk("R3 default addr3", mgmtRdata, 16'h3000);
    traffic(8);                                 // R8 normal path
    mgmtSel = 1'b0; cyc(1);
    chk("R5 deselected read", mgmtRdata, 16'h0);
    // R4 plus reserved bits ignored (R5)
    wr(16'h297F); cyc(1);
    chk("R4 write pattern", mgmtRdata, 16'h2900);
    wr(16'h4000); traffic(8);                   // R6 loopback, no col test
    wr(16'h4080); traffic(8);                   // R7 loopback col test
    wr(16'h4480); traffic(4);                   // R9 isolate beats loopback
    wr(16'h0B80); cyc(2);
    // R1 soft reset, R2 writes blocked
    wr(16'h8000);
    chk("R1 pending reads 1", mgmtRdata & 16'h8000, 16'h8000);
    wr(16'h4000); wr(16'h8000);
    chk("R2 write ignored", mgmtRdata, 16'hB000);
    cyc(RC + 2);
    chk("R1 self-cleared", mgmtRdata, 16'h3000);
    wr(16'h0100); cyc(1);
    chk("R4 write after reset", mgmtRdata, 16'h0100);
    // R10 hardware reset aborts soft reset
    wr(16'h8000); cyc(3);
    rstN = 1'b0; cyc(1);
    phyAddr = 5'd0; cyc(1); rstN = 1'b1; cyc(1);
    chk("R10 abort defaults", mgmtRdata, 16'h3400);
    cyc(RC + 2);
    chk("R10 no done pulse", {15'h0, resetDone}, 16'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule